// File: doc/BRIEF.md
# Scanline Counter with Dual Display Status

This block keeps the vertical timing of a two-screen handheld display and one display-status register for each of two processors. A free-running cycle counter splits time into lines of fixed length. A line counter steps through the frame and wraps back to line 0 after the last line. The block raises and drops a vertical-blank flag at fixed lines.

Each processor owns a 16-bit status register and a 9-bit line-match value. At every line boundary the new line number is compared with each match value. The compare updates a match flag, and it can raise a one-cycle interrupt request. A second request marks the start of vertical blank.

Software writes only the control bits of its status register. The flags that the hardware maintains survive any write. The status and the current line can be read separately, and also as one 32-bit word.

Top module: `scanline_status`

## Requirements
- R1: The line counter advances by one every LINE_CYCLES clocks, and after line TOTAL_LINES-1 it returns to 0. The line shown on `line_rd` changes only on the first clock of a line.
- R2: After a synchronous active-low reset:
  - the line and both status registers read 0,
  - both match values are 0,
  - no interrupt is requested.
  No match compare takes place until the first line boundary.
- R3: In the same clock that the line becomes VIS_LINES, status bit 0 is set in both registers. In the clock that the line becomes TOTAL_LINES-1, bit 0 is cleared in both.
- R4: A vblank request (`vblank_irq[p]`) is a one-cycle pulse. It is asserted in the clock that the line becomes VIS_LINES, for each processor p whose status bit 3 was set before that boundary.
- R5: At every line boundary, status bit 2 of each processor becomes 1 if the new line equals that processor's match value, and 0 otherwise.
- R6: A match request (`match_irq[p]`) is a one-cycle pulse. It is asserted in the clock that bit 2 is set by a boundary, provided status bit 5 was set before that boundary.
- R7: A status write loads the match value. Written bits 15:8 become match bits 7:0, and written bit 7 becomes match bit 8. A compare uses the match value held before a write in the same clock.
- R8: A write changes only status bits 3, 4, 5 and 7 to 15, which take the written value. Bits 0, 1, 2 and 6 keep their hardware value. Bits 1 and 6 always read 0. Bit 4 is stored but has no effect.
- R9: `wideN_rd` returns the line count in bits 31:16 and statusN in bits 15:0. `line_rd` is the line count zero-extended to 16 bits.
- R10: The two processors' status registers, match values and requests are independent of each other. They share only the line counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en0 | input | 1 | Status write strobe, processor 0 |
| wr_data0 | input | 16 | Status write data, processor 0 |
| wr_en1 | input | 1 | Status write strobe, processor 1 |
| wr_data1 | input | 16 | Status write data, processor 1 |
| stat0_rd | output | 16 | Status register, processor 0 |
| stat1_rd | output | 16 | Status register, processor 1 |
| line_rd | output | 16 | Current line, zero-extended |
| wide0_rd | output | 32 | Line and status 0, read as one word |
| wide1_rd | output | 32 | Line and status 1, read as one word |
| vblank_irq | output | 2 | Vblank request pulse per processor |
| match_irq | output | 2 | Line-match request pulse per processor |

## Verification
All line, flag and request changes appear at the clock edge that ends the last cycle of a line. They therefore change on the same edge as the new line number, with no extra stage. A write shows in the status and match value one edge after its strobe is sampled.

The bench model steps on the same edge and uses the values sampled at that edge. The bench compares every output at the falling edge that follows. A late or early flag, or a request that lasts more than one cycle, appears as a mismatch in that very cycle.

// File: rtl/scan_pkg.sv
// Package: shared constants for the scanline/status block.
// Assumes 16-bit status registers and 9-bit match values.
package scan_pkg;
    localparam int          STAT_W       = 16;
    localparam int          MATCH_W      = 9;
    localparam logic [15:0] STAT_WR_MASK = 16'hFFB8;
    localparam int          B_VBLANK     = 0;
    localparam int          B_MATCH      = 2;
    localparam int          B_VB_EN      = 3;
    localparam int          B_MATCH_EN   = 5;
    typedef logic [STAT_W-1:0]  stat_t;
    typedef logic [MATCH_W-1:0] match_t;
endpackage

// File: rtl/line_timer.sv
// line_timer: divides the clock into lines and counts lines in a frame.
// Assumes LINE_CYCLES >= 2 and TOTAL_LINES >= 2. It exposes the boundary
// strobe and the next line combinationally, so that status logic can
// update on the same edge as the line register.
module line_timer #(
    parameter int LINE_CYCLES = 4260,
    parameter int TOTAL_LINES = 263,
    localparam int CYC_W  = $clog2(LINE_CYCLES),
    localparam int LINE_W = $clog2(TOTAL_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [LINE_W-1:0] line_q,
    output logic              wrap_o,
    output logic [LINE_W-1:0] line_next_o
);
    logic [CYC_W-1:0] cyc_q;

    // Boundary strobe and next line number.
    always_comb begin
        wrap_o      = (cyc_q == CYC_W'(LINE_CYCLES - 1));
        line_next_o = (line_q == LINE_W'(TOTAL_LINES - 1)) ? '0 : line_q + 1'b1;
    end

    // Cycle and line counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q  <= '0;
            line_q <= '0;
        end else if (wrap_o) begin
            cyc_q  <= '0;
            line_q <= line_next_o;
        end else begin
            cyc_q  <= cyc_q + 1'b1;
        end
    end

    AST_LINE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (line_q != $past(line_q)) |-> (cyc_q == '0)); // R1
    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(line_q) < TOTAL_LINES); // R1
endmodule

// File: rtl/stat_reg.sv
// stat_reg: one processor's status register, its match value and its two
// interrupt pulses. Assumes VIS_LINES < TOTAL_LINES-1. The hardware flags
// and the software bits update together, on disjoint bits.
module stat_reg
    import scan_pkg::*;
#(
    parameter int VIS_LINES   = 192,
    parameter int TOTAL_LINES = 263,
    localparam int LINE_W = $clog2(TOTAL_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  stat_t             wr_data,
    input  logic              wrap,
    input  logic [LINE_W-1:0] line_next,
    input  logic [LINE_W-1:0] line_q,
    output stat_t             stat_q,
    output logic              vb_irq,
    output logic              m_irq
);
    match_t match_q;
    logic   ent_vis, ent_last, eq;
    stat_t  stat_d;

    // Boundary events and the hardware/software merge of the next status.
    always_comb begin
        ent_vis  = wrap && (32'(line_next) == VIS_LINES);
        ent_last = wrap && (32'(line_next) == TOTAL_LINES - 1);
        eq       = (16'(line_next) == 16'(match_q));
        stat_d   = stat_q & ~STAT_WR_MASK;
        if (ent_vis)       stat_d[B_VBLANK] = 1'b1;
        else if (ent_last) stat_d[B_VBLANK] = 1'b0;
        if (wrap)          stat_d[B_MATCH]  = eq;
        stat_d[1] = 1'b0;
        stat_d[6] = 1'b0;
        stat_d = stat_d | ((wr_en ? wr_data : stat_q) & STAT_WR_MASK);
    end

    // Status, match value and request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q  <= '0;
            match_q <= '0;
            vb_irq  <= 1'b0;
            m_irq   <= 1'b0;
        end else begin
            stat_q <= stat_d;
            if (wr_en) match_q <= {wr_data[7], wr_data[15:8]};
            vb_irq <= ent_vis && stat_q[B_VB_EN];
            m_irq  <= wrap && eq && stat_q[B_MATCH_EN];
        end
    end

    AST_VB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        vb_irq |=> !vb_irq); // R4
    AST_VB_AT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        vb_irq |-> (32'(line_q) == VIS_LINES && stat_q[B_VBLANK])); // R4
    AST_VB_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(line_q) >= VIS_LINES && 32'(line_q) < TOTAL_LINES - 1) |-> stat_q[B_VBLANK]); // R3
    AST_MATCH_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        m_irq |-> stat_q[B_MATCH]); // R6
    AST_MATCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        m_irq |=> !m_irq); // R6
    AST_HW_ONLY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_q[1] && !stat_q[6]); // R8
endmodule

// File: rtl/scanline_status.sv
// scanline_status: shared line counter with two per-processor status
// registers. Assumes one clock domain and a synchronous active-low reset.
module scanline_status
    import scan_pkg::*;
#(
    parameter int LINE_CYCLES = 4260,
    parameter int TOTAL_LINES = 263,
    parameter int VIS_LINES   = 192,
    localparam int NUM_CPU = 2,
    localparam int LINE_W  = $clog2(TOTAL_LINES)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en0,
    input  logic [15:0] wr_data0,
    input  logic        wr_en1,
    input  logic [15:0] wr_data1,
    output logic [15:0] stat0_rd,
    output logic [15:0] stat1_rd,
    output logic [15:0] line_rd,
    output logic [31:0] wide0_rd,
    output logic [31:0] wide1_rd,
    output logic [1:0]  vblank_irq,
    output logic [1:0]  match_irq
);
    logic [LINE_W-1:0] line_q, line_next;
    logic              wrap;
    logic              wr_en_a [NUM_CPU];
    stat_t             wr_dat_a[NUM_CPU];
    stat_t             stat_a  [NUM_CPU];

    line_timer #(.LINE_CYCLES(LINE_CYCLES), .TOTAL_LINES(TOTAL_LINES)) u_timer (
        .clk(clk), .rst_n(rst_n), .line_q(line_q),
        .wrap_o(wrap), .line_next_o(line_next));

    // Gather the per-processor write ports into arrays.
    always_comb begin
        wr_en_a[0]  = wr_en0;   wr_en_a[1]  = wr_en1;
        wr_dat_a[0] = wr_data0; wr_dat_a[1] = wr_data1;
    end

    for (genvar p = 0; p < NUM_CPU; p++) begin : g_cpu
        stat_reg #(.VIS_LINES(VIS_LINES), .TOTAL_LINES(TOTAL_LINES)) u_stat (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_en_a[p]), .wr_data(wr_dat_a[p]),
            .wrap(wrap), .line_next(line_next), .line_q(line_q),
            .stat_q(stat_a[p]), .vb_irq(vblank_irq[p]), .m_irq(match_irq[p]));
    end

    // Read views.
    always_comb begin
        line_rd  = 16'(line_q);
        stat0_rd = stat_a[0];
        stat1_rd = stat_a[1];
        wide0_rd = {16'(line_q), stat_a[0]};
        wide1_rd = {16'(line_q), stat_a[1]};
    end
endmodule

// File: tb/scanline_status_bench.sv
module scanline_status_bench;
    localparam int PERIOD = 10;
    localparam int LC = 5, TL = 16, VL = 10;

    logic clk = 0, rst_n = 0;
    logic [15:0] wd[2];
    logic        we[2];
    logic [15:0] stat0_rd, stat1_rd, line_rd;
    logic [31:0] wide0_rd, wide1_rd;
    logic [1:0]  vblank_irq, match_irq;

    int checks = 0, fails = 0;
    int m_cyc, m_line;
    logic [15:0] m_stat[2];
    int m_match[2];
    logic m_vb[2], m_mi[2];

    always #(PERIOD/2) clk = ~clk;

    scanline_status #(.LINE_CYCLES(LC), .TOTAL_LINES(TL), .VIS_LINES(VL)) u_scanline_status (
        .clk(clk), .rst_n(rst_n), .wr_en0(we[0]), .wr_data0(wd[0]),
        .wr_en1(we[1]), .wr_data1(wd[1]), .stat0_rd(stat0_rd), .stat1_rd(stat1_rd),
        .line_rd(line_rd), .wide0_rd(wide0_rd), .wide1_rd(wide1_rd),
        .vblank_irq(vblank_irq), .match_irq(match_irq));

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cyc = 0; m_line = 0;
            for (int p = 0; p < 2; p++) begin
                m_stat[p] = 0; m_match[p] = 0; m_vb[p] = 0; m_mi[p] = 0;
            end
        end else begin
            bit bnd;
            int nl;
            bnd = (m_cyc == LC - 1);
            nl  = (m_line == TL - 1) ? 0 : m_line + 1;
            for (int p = 0; p < 2; p++) begin
                logic [15:0] old, ns;
                old = m_stat[p]; ns = old;
                if (bnd) begin
                    if (nl == VL) ns[0] = 1'b1;
                    else if (nl == TL - 1) ns[0] = 1'b0;
                    ns[2] = (nl == m_match[p]);
                end
                m_vb[p] = bnd && nl == VL && old[3];
                m_mi[p] = bnd && nl == m_match[p] && old[5];
                if (we[p]) begin
                    ns = (ns & 16'h0047) | (wd[p] & 16'hFFB8);
                    m_match[p] = ((int'(wd[p]) >> 8) & 255) | ((int'(wd[p]) & 128) << 1);
                end
                m_stat[p] = ns;
            end
            if (bnd) begin m_cyc = 0; m_line = nl; end
            else m_cyc++;
        end
    end

    // Compare every output on each falling edge after reset.
    always @(negedge clk) if (rst_n) begin
        check(line_rd == 16'(m_line), "R1 line", line_rd, m_line);
        check(stat0_rd[0] == m_stat[0][0] && stat1_rd[0] == m_stat[1][0], "R3 vblank flag",
              {stat1_rd[0], stat0_rd[0]}, {m_stat[1][0], m_stat[0][0]});
        check(stat0_rd[2] == m_stat[0][2], "R5 R7 match flag cpu0", stat0_rd[2], m_stat[0][2]);
        check(stat1_rd[2] == m_stat[1][2], "R5 R7 R10 match flag cpu1", stat1_rd[2], m_stat[1][2]);
        check(stat0_rd == m_stat[0], "R8 status cpu0", stat0_rd, m_stat[0]);
        check(stat1_rd == m_stat[1], "R8 R10 status cpu1", stat1_rd, m_stat[1]);
        check(vblank_irq == {m_vb[1], m_vb[0]}, "R4 R10 vblank irq", vblank_irq, {m_vb[1], m_vb[0]});
        check(match_irq == {m_mi[1], m_mi[0]}, "R6 R10 match irq", match_irq, {m_mi[1], m_mi[0]});
        check(wide0_rd == {16'(m_line), m_stat[0]} && wide1_rd == {16'(m_line), m_stat[1]},
              "R9 wide read", {wide1_rd, wide0_rd}, {16'(m_line), m_stat[1], 16'(m_line), m_stat[0]});
    end

    task automatic wr(input int p, input logic [15:0] v);
        @(negedge clk); we[p] = 1; wd[p] = v;
        @(negedge clk); we[p] = 0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 200000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        we[0] = 0; we[1] = 0; wd[0] = 0; wd[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R2: reset state before the first boundary
        check(line_rd == 0 && stat0_rd == 0 && stat1_rd == 0, "R2 reset state",
              {line_rd, stat0_rd, stat1_rd}, 0);
        check(vblank_irq == 0 && match_irq == 0, "R2 reset irqs", {vblank_irq, match_irq}, 0);
        // cpu0: match 3, vblank and match enables
        wr(0, 16'h0328);
        // cpu1: match 259 via bit 7, try to set the hardware bits
        wr(1, 16'h03E7);
        run(2 * LC * TL);
        // cpu1: match last line, only bit 4 set
        wr(1, 16'h0F10);
        run(LC * TL);
        // cpu0: match the vblank line with both enables
        wr(0, 16'h0A38);
        run(LC * TL);
        // cpu0: match line 0 (wrap); cpu1 enables vblank request
        wr(0, 16'h0030);
        wr(1, 16'h0008);
        run(LC * TL + 7);
        // write in the last cycle of a line
        while (!(line_rd == 16'(TL - 1) && m_cyc == LC - 2)) @(negedge clk);
        wr(0, 16'h0138);
        run(LC * TL);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule